// File: doc/BRIEF.md
# Expansion Bus Chip-Select Controller

This block connects a simple internal request port to an external expansion bus with a 32-bit data path, a 25-bit address and eight active-low chip selects. Each chip select has its own configuration word. The word holds an enable bit, a device width, a device mode and timing counts. A request names a chip select, an address, byte enables, write data and an optional burst length. The block then runs the bus cycle and returns one response per transferred word.

There are two device modes. The plain mode runs a three-phase strobe cycle: setup, pulse and hold, each with its own programmable length. The synchronous flash mode runs the same single-word cycle. It can also run a read burst of 1 to 8 words. A burst opens with a one-clock address-latch pulse and then waits a programmed latency. After that it takes a data word only in clocks where the active-low wait input is released.

Chip select 0 leaves reset already enabled with the slowest plain-mode timing, so a boot flash can be read at once. Its width comes from two bootstrap pins that are sampled while reset is held. All other chip selects start disabled. Configuration is written through a one-cycle write port.

Top module: `exbus_cs_ctrl`

## Requirements
- R1: While reset is held and after its release, all chip selects, `ex_rd_n` and `ex_wr_n` are high, `ex_ale` is low, `rsp_valid` is low and `req_ready` is high.
- R2: After reset, chip select 0 is enabled in plain mode with 16 clocks each of setup, pulse and hold. A read on it holds `ex_cs_n[0]` low for 48 clocks and `ex_rd_n` low for 16 clocks, starting in the 17th clock.
- R3: The width of chip select 0 is the code {`strap_a7`,`strap_a0`}, taken from the last clock of reset. Changing the straps afterwards has no effect on it.
- R4: After reset, chip selects 1 to 7 are disabled. A request to a disabled chip select returns `rsp_valid` with `rsp_err` and `rsp_last` one clock after acceptance, and no chip select, strobe or `ex_ale` moves.
- R5: Configuration word layout: bit 0 enable; bits 2:1 width (0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit); bit 3 synchronous flash mode; bits 7:4 setup S; bits 11:8 pulse P; bits 15:12 hold H; bits 19:16 latency L; bits 21:20 burst code (0 = 8 words, 1 = 16 words). A single-word access holds its chip select low for (S+1)+(P+1)+(H+1) clocks, with the strobe low only for the P+1 clocks that follow the first S+1.
- R6: A single-word read returns the `ex_din` value present in the last pulse clock, with lanes above the device width forced to zero. `rsp_valid` pulses in the clock after the chip select goes high.
- R7: A write pulses `ex_wr_n` low for P+1 clocks and keeps `ex_rd_n` high. `ex_doe` is high and `ex_dout` equals the write data while `ex_wr_n` is low. The response carries no error.
- R8: At most one chip select is low at any time, and it is the one the request named.
- R9: A burst read (`req_burst` set, read, synchronous flash mode) drives `ex_ale` high for exactly one clock with the chip select low and `ex_rd_n` high. The first clock in which data may be taken comes L+2 clocks after that clock.
- R10: In the data phase of a burst, a word is taken only in clocks with `ex_wait_n` high. Each word appears on `rsp_rdata` with `rsp_valid` one clock later. Exactly `req_len`+1 words are returned, and `rsp_last` is set on the final one only. The chip select rises after the clock that took the final word.
- R11: A read without `req_burst` in synchronous flash mode, and any request with `req_burst` set in plain mode, runs as a single-word strobe cycle with no `ex_ale` pulse.
- R12: Byte enables follow the device width: 8-bit drives `ex_be_n` = {111, ~be[0]}; 16-bit drives {11, ~be[1:0]}; 32-bit drives ~be. Bursts enable every lane of the width. Outside an access all four are high.
- R13: A configuration write that selects synchronous flash mode is discarded unless the device is 16-bit with burst code 1, or 32-bit with burst code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Expansion bus clock, up to 80 MHz |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_a0 | input | 1 | Bootstrap pin, low bit of the chip-select 0 width code |
| strap_a7 | input | 1 | Bootstrap pin, high bit of the chip-select 0 width code |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Chip select whose configuration is written |
| cfg_wdata | input | 22 | Configuration word (layout in R5) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Request a synchronous burst read |
| req_len | input | 3 | Burst length minus one |
| req_cs | input | 3 | Target chip select |
| req_addr | input | 25 | Word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables, active high |
| rsp_valid | output | 1 | Response word present for one clock |
| rsp_err | output | 1 | Access hit a disabled chip select |
| rsp_last | output | 1 | Final response of the request |
| rsp_rdata | output | 32 | Read data |
| ex_addr | output | 25 | Bus address |
| ex_be_n | output | 4 | Byte enables, active low |
| ex_cs_n | output | 8 | Chip selects, active low |
| ex_rd_n | output | 1 | Read strobe, active low |
| ex_wr_n | output | 1 | Write strobe, active low |
| ex_ale | output | 1 | Address-latch pulse for bursts |
| ex_dout | output | 32 | Write data to the bus |
| ex_doe | output | 1 | Data output enable |
| ex_din | input | 32 | Read data from the bus |
| ex_wait_n | input | 1 | Active-low wait from a synchronous device |

## Verification
The assertions assume three things about the inputs. A request is raised only while `req_ready` is high. Each request stays for a single clock. `req_cs` stays within the eight chip selects. They also assume that `ex_wait_n` is released at least once in every few data clocks, so bursts finish. The bench issues every request from an idle state and drops `req_valid` after one clock. It drives `ex_wait_n` from a fixed modulo-3 pattern that is never low for two clocks in a row. It changes configuration only between accesses, so the assertions on strobe order and wait qualification watch only legal traffic.

// File: rtl/exbus_pkg.sv
// Shared types and helpers for the expansion bus controller.
// Assumes a 32-bit data path and 4-bit timing fields.
package exbus_pkg;

    localparam int TW    = 4;
    localparam int DW    = 32;
    localparam int BEW   = DW / 8;
    localparam int CFG_W = 22;

    typedef enum logic [1:0] {
        WD_8   = 2'd0,
        WD_16  = 2'd1,
        WD_32  = 2'd2,
        WD_32X = 2'd3
    } width_e;

    // Run-time view of one chip-select configuration.
    typedef struct packed {
        logic          en;
        width_e        width;
        logic          sync;
        logic [TW-1:0] setup;
        logic [TW-1:0] pulse;
        logic [TW-1:0] hold;
        logic [TW-1:0] lat;
    } rt_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SETUP, ST_PULSE, ST_HOLD, ST_ALE, ST_LAT, ST_DATA
    } st_e;

    // Unpack a configuration word into the run-time fields.
    function automatic rt_t cfg_decode(input logic [CFG_W-1:0] w);
        rt_t r;
        r.en    = w[0];
        r.width = width_e'(w[2:1]);
        r.sync  = w[3];
        r.setup = w[7:4];
        r.pulse = w[11:8];
        r.hold  = w[15:12];
        r.lat   = w[19:16];
        return r;
    endfunction

    // Synchronous flash needs 16-word bursts at 16 bits, 8-word at 32 bits.
    function automatic logic sync_ok(input logic [1:0] wcode, input logic [1:0] bcode);
        return ((wcode == 2'd1) && (bcode == 2'd1)) ||
               ((wcode[1] == 1'b1) && (bcode == 2'd0));
    endfunction

endpackage

// File: rtl/exbus_cfg_bank.sv
// Per-chip-select configuration store.
// Entry 0 resets to slow plain-mode timing with the width from the straps
// seen while reset is held; the others reset disabled. Writes that ask for
// synchronous flash mode with an inconsistent burst code are dropped.
module exbus_cfg_bank
    import exbus_pkg::*;
#(
    parameter int NUM_CS = 8,
    localparam int CS_W  = $clog2(NUM_CS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   strap_a0,
    input  logic                   strap_a7,
    input  logic                   cfg_we,
    input  logic [CS_W-1:0]        cfg_sel,
    input  logic [CFG_W-1:0]       cfg_wdata,
    output rt_t  [NUM_CS-1:0]      cfg_tab
);

    logic wr_ok;

    // A sync-mode word is only kept if its burst code fits its width.
    always_comb wr_ok = !cfg_wdata[3] || sync_ok(cfg_wdata[2:1], cfg_wdata[21:20]);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_ent
        // Hold one configuration entry; reset value depends on the entry index.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                if (i == 0) begin
                    cfg_tab[i].en    <= 1'b1;
                    cfg_tab[i].width <= width_e'({strap_a7, strap_a0});
                    cfg_tab[i].sync  <= 1'b0;
                    cfg_tab[i].setup <= '1;
                    cfg_tab[i].pulse <= '1;
                    cfg_tab[i].hold  <= '1;
                    cfg_tab[i].lat   <= '1;
                end else begin
                    cfg_tab[i] <= '0;
                end
            end else if (cfg_we && cfg_sel == CS_W'(i) && wr_ok) begin
                cfg_tab[i] <= cfg_decode(cfg_wdata);
            end
        end

        // R13: a rejected write leaves the entry untouched.
        a_r13_bad_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_sel == CS_W'(i) && !wr_ok) |=> $stable(cfg_tab[i]));
    end

endmodule

// File: rtl/exbus_lane.sv
// Byte-lane shaping by device width: maps request byte enables onto the
// bus and clears read lanes above the device width. Purely combinational.
module exbus_lane
    import exbus_pkg::*;
(
    input  width_e          width,
    input  logic [BEW-1:0]  be,
    input  logic [DW-1:0]   din,
    output logic [BEW-1:0]  be_n,
    output logic [DW-1:0]   rdat
);

    // Select active lanes and mask read data for the programmed width.
    always_comb begin
        unique case (width)
            WD_8: begin
                be_n = {3'b111, ~be[0]};
                rdat = {24'd0, din[7:0]};
            end
            WD_16: begin
                be_n = {2'b11, ~be[1:0]};
                rdat = {16'd0, din[15:0]};
            end
            default: begin
                be_n = ~be;
                rdat = din;
            end
        endcase
    end

endmodule

// File: rtl/exbus_seq.sv
// Bus cycle sequencer. Runs setup/pulse/hold strobe cycles and synchronous
// flash burst reads (address latch, latency, wait-qualified data).
// Assumes requests arrive only while req_ready is high; configuration of
// the accepted chip select is copied at acceptance.
module exbus_seq
    import exbus_pkg::*;
#(
    parameter int NUM_CS = 8,
    parameter int ADDR_W = 25,
    localparam int CS_W  = $clog2(NUM_CS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_we,
    input  logic               req_burst,
    input  logic [2:0]         req_len,
    input  logic [CS_W-1:0]    req_cs,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DW-1:0]      req_wdata,
    input  logic [BEW-1:0]     req_be,
    input  rt_t                cfg_cur,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic               rsp_last,
    output logic [DW-1:0]      rsp_rdata,
    output logic               bus_act,
    output logic [CS_W-1:0]    bus_cs,
    output logic [ADDR_W-1:0]  ex_addr,
    output logic [BEW-1:0]     ex_be_n,
    output logic               ex_rd_n,
    output logic               ex_wr_n,
    output logic               ex_ale,
    output logic [DW-1:0]      ex_dout,
    output logic               ex_doe,
    input  logic [DW-1:0]      ex_din,
    input  logic               ex_wait_n
);

    st_e               st;
    logic [TW-1:0]     cnt;
    logic              we_q;
    width_e            width_q;
    logic [TW-1:0]     pulse_q, hold_q, lat_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DW-1:0]     wdata_q;
    logic [BEW-1:0]    be_q;
    logic [CS_W-1:0]   cs_q;
    logic [2:0]        len_q, beat_q;
    logic              rsp_valid_q, rsp_err_q, rsp_last_q;
    logic [DW-1:0]     rdata_q;
    logic [BEW-1:0]    lane_be_n;
    logic [DW-1:0]     lane_rd;
    logic              take, go_burst;

    always_comb take     = req_valid && (st == ST_IDLE) && cfg_cur.en;
    always_comb go_burst = req_burst && !req_we && cfg_cur.sync;

    exbus_lane u_lane (
        .width (width_q),
        .be    (be_q),
        .din   (ex_din),
        .be_n  (lane_be_n),
        .rdat  (lane_rd)
    );

    // Capture request fields and the chip-select timing at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            width_q <= WD_32;
            pulse_q <= '0;
            hold_q  <= '0;
            lat_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            cs_q    <= '0;
            len_q   <= '0;
        end else if (take) begin
            we_q    <= req_we;
            width_q <= cfg_cur.width;
            pulse_q <= cfg_cur.pulse;
            hold_q  <= cfg_cur.hold;
            lat_q   <= cfg_cur.lat;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= go_burst ? '1 : req_be;
            cs_q    <= req_cs;
            len_q   <= req_len;
        end
    end

    // Phase state machine, phase counter, beat counter and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            cnt         <= '0;
            beat_q      <= '0;
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            rsp_last_q  <= 1'b0;
            rdata_q     <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (req_valid && !cfg_cur.en) begin
                        rsp_valid_q <= 1'b1;
                        rsp_err_q   <= 1'b1;
                        rsp_last_q  <= 1'b1;
                    end else if (take) begin
                        rsp_err_q <= 1'b0;
                        if (go_burst) begin
                            st <= ST_ALE;
                        end else begin
                            st  <= ST_SETUP;
                            cnt <= cfg_cur.setup;
                        end
                    end
                end
                ST_SETUP: begin
                    if (cnt == '0) begin
                        st  <= ST_PULSE;
                        cnt <= pulse_q;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (cnt == '0) begin
                        if (!we_q) rdata_q <= lane_rd;
                        st  <= ST_HOLD;
                        cnt <= hold_q;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (cnt == '0) begin
                        st          <= ST_IDLE;
                        rsp_valid_q <= 1'b1;
                        rsp_last_q  <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_ALE: begin
                    st  <= ST_LAT;
                    cnt <= lat_q;
                end
                ST_LAT: begin
                    if (cnt == '0) begin
                        st     <= ST_DATA;
                        beat_q <= '0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_DATA: begin
                    if (ex_wait_n) begin
                        rdata_q     <= lane_rd;
                        rsp_valid_q <= 1'b1;
                        rsp_last_q  <= (beat_q == len_q);
                        beat_q      <= beat_q + 1'b1;
                        if (beat_q == len_q) st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Decode bus pins from the current phase.
    always_comb begin
        req_ready = (st == ST_IDLE);
        bus_act   = (st != ST_IDLE);
        bus_cs    = cs_q;
        ex_addr   = addr_q;
        ex_be_n   = bus_act ? lane_be_n : '1;
        ex_rd_n   = !(((st == ST_PULSE) && !we_q) || (st == ST_LAT) || (st == ST_DATA));
        ex_wr_n   = !((st == ST_PULSE) && we_q);
        ex_ale    = (st == ST_ALE);
        ex_dout   = wdata_q;
        ex_doe    = we_q && ((st == ST_SETUP) || (st == ST_PULSE) || (st == ST_HOLD));
        rsp_valid = rsp_valid_q;
        rsp_err   = rsp_err_q;
        rsp_last  = rsp_last_q;
        rsp_rdata = rdata_q;
    end

    // R9: the address latch pulse lasts one clock and is followed by the read strobe.
    a_r9_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ex_ale |=> (!ex_ale && !ex_rd_n));

    // R10: a burst word is only returned for a clock with wait released.
    a_r10_beat_needs_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(st == ST_DATA)) |-> $past(ex_wait_n));

    // R4: a disabled target answers with an error next clock and stays off the bus.
    a_r4_disabled_error: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !cfg_cur.en) |=> (rsp_valid && rsp_err && !bus_act));

endmodule

// File: rtl/exbus_cs_ctrl.sv
// Expansion bus controller top: configuration bank, cycle sequencer and
// chip-select decode. Assumes a request is raised only while req_ready is
// high and is held for one clock.
module exbus_cs_ctrl
    import exbus_pkg::*;
#(
    parameter int NUM_CS = 8,
    parameter int ADDR_W = 25,
    localparam int CS_W  = $clog2(NUM_CS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strap_a0,
    input  logic               strap_a7,
    input  logic               cfg_we,
    input  logic [CS_W-1:0]    cfg_sel,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_we,
    input  logic               req_burst,
    input  logic [2:0]         req_len,
    input  logic [CS_W-1:0]    req_cs,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DW-1:0]      req_wdata,
    input  logic [BEW-1:0]     req_be,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic               rsp_last,
    output logic [DW-1:0]      rsp_rdata,
    output logic [ADDR_W-1:0]  ex_addr,
    output logic [BEW-1:0]     ex_be_n,
    output logic [NUM_CS-1:0]  ex_cs_n,
    output logic               ex_rd_n,
    output logic               ex_wr_n,
    output logic               ex_ale,
    output logic [DW-1:0]      ex_dout,
    output logic               ex_doe,
    input  logic [DW-1:0]      ex_din,
    input  logic               ex_wait_n
);

    rt_t [NUM_CS-1:0] cfg_tab;
    rt_t              cfg_cur;
    logic             bus_act;
    logic [CS_W-1:0]  bus_cs;

    // Configuration of the chip select a new request names.
    always_comb cfg_cur = cfg_tab[req_cs];

    exbus_cfg_bank #(.NUM_CS(NUM_CS)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_a0  (strap_a0),
        .strap_a7  (strap_a7),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_tab   (cfg_tab)
    );

    exbus_seq #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_we    (req_we),
        .req_burst (req_burst),
        .req_len   (req_len),
        .req_cs    (req_cs),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .cfg_cur   (cfg_cur),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_last  (rsp_last),
        .rsp_rdata (rsp_rdata),
        .bus_act   (bus_act),
        .bus_cs    (bus_cs),
        .ex_addr   (ex_addr),
        .ex_be_n   (ex_be_n),
        .ex_rd_n   (ex_rd_n),
        .ex_wr_n   (ex_wr_n),
        .ex_ale    (ex_ale),
        .ex_dout   (ex_dout),
        .ex_doe    (ex_doe),
        .ex_din    (ex_din),
        .ex_wait_n (ex_wait_n)
    );

    // One active-low select per chip select, low only for the active target.
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign ex_cs_n[i] = !(bus_act && (bus_cs == CS_W'(i)));
    end

    // R8: never more than one chip select low.
    a_r8_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ex_cs_n));

    // R7: read and write strobes never overlap.
    a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ex_rd_n && !ex_wr_n));

    // R5: a strobe is only low inside a chip-select window.
    a_r5_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_rd_n || !ex_wr_n) |-> (ex_cs_n != '1));

    // R1: while ready, the bus is quiet.
    a_r1_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ex_cs_n == '1 && ex_rd_n && ex_wr_n && !ex_ale && ex_be_n == '1));

endmodule

// File: tb/tb_exbus_cs_ctrl.sv
module tb_exbus_cs_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NCS = 8;
    localparam int AW  = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_a0 = 1'b0, strap_a7 = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [21:0] cfg_wdata = '0;
    logic        req_valid = 1'b0, req_we = 1'b0, req_burst = 1'b0;
    logic        req_ready;
    logic [2:0]  req_len = '0, req_cs = '0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        rsp_valid, rsp_err, rsp_last;
    logic [31:0] rsp_rdata;
    logic [AW-1:0] ex_addr;
    logic [3:0]  ex_be_n;
    logic [7:0]  ex_cs_n;
    logic        ex_rd_n, ex_wr_n, ex_ale, ex_doe;
    logic [31:0] ex_dout;
    logic [31:0] ex_din = '0;
    logic        ex_wait_n = 1'b1;

    exbus_cs_ctrl dut (
        .clk(clk), .rst_n(rst_n), .strap_a0(strap_a0), .strap_a7(strap_a7),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_burst(req_burst), .req_len(req_len), .req_cs(req_cs),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_last(rsp_last),
        .rsp_rdata(rsp_rdata), .ex_addr(ex_addr), .ex_be_n(ex_be_n),
        .ex_cs_n(ex_cs_n), .ex_rd_n(ex_rd_n), .ex_wr_n(ex_wr_n),
        .ex_ale(ex_ale), .ex_dout(ex_dout), .ex_doe(ex_doe),
        .ex_din(ex_din), .ex_wait_n(ex_wait_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;

    // Monitor state, cleared before each access.
    int gcnt = 0, ale_g = 0, wseed = 0;
    int n_cs, n_rd, n_wr, n_ale, rd_first, nbeats, exp_cs;
    logic [3:0]  be_obs;
    logic [31:0] din_rd, exp_wd;
    logic [31:0] beat_d [16];
    logic        beat_l [16];
    bit err_seen, last_seen, cs_bad, dout_bad, ale_rd_bad;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Drive bus inputs and record what the pins did, away from the active edge.
    always @(negedge clk) begin
        int k;
        gcnt++;
        if (ex_ale) ale_g = gcnt;
        k = gcnt - ale_g;
        ex_wait_n = ((k + wseed) % 3) != 0;
        ex_din = {8'hC3, 24'(gcnt)};
        if (ex_cs_n != 8'hFF) begin
            n_cs++;
            be_obs = ex_be_n;
            if (ex_cs_n != ~(8'h01 << exp_cs)) cs_bad = 1;
        end
        if (!ex_rd_n) begin
            if (rd_first < 0) rd_first = n_cs - 1;
            n_rd++;
            din_rd = ex_din;
        end
        if (!ex_wr_n) begin
            n_wr++;
            if (ex_dout != exp_wd || !ex_doe) dout_bad = 1;
        end
        if (ex_ale) begin
            n_ale++;
            if (!ex_rd_n) ale_rd_bad = 1;
        end
        if (rsp_valid) begin
            if (nbeats < 16) begin
                beat_d[nbeats] = rsp_rdata;
                beat_l[nbeats] = rsp_last;
            end
            nbeats++;
            if (rsp_err) err_seen = 1;
            if (rsp_last) last_seen = 1;
        end
    end

    function automatic logic [3:0] x_be_n(input int w, input logic [3:0] be);
        if (w == 0) return {3'b111, ~be[0]};
        if (w == 1) return {2'b11, ~be[1:0]};
        return ~be;
    endfunction

    function automatic logic [31:0] x_mask(input int w, input logic [31:0] d);
        if (w == 0) return d & 32'h0000_00FF;
        if (w == 1) return d & 32'h0000_FFFF;
        return d;
    endfunction

    function automatic logic [21:0] mkcfg(input int en, input int w, input int sy,
                                          input int s, input int p, input int h,
                                          input int l, input int bc);
        return {2'(bc), 4'(l), 4'(h), 4'(p), 4'(s), 1'(sy), 2'(w), 1'(en)};
    endfunction

    task automatic do_reset(input logic a7, input logic a0);
        @(negedge clk);
        rst_n = 0; strap_a7 = a7; strap_a0 = a0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic cfg_write(input int sel, input logic [21:0] w);
        @(negedge clk);
        cfg_we = 1; cfg_sel = 3'(sel); cfg_wdata = w;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic do_req(input int cs, input bit we, input bit burst, input int len,
                          input logic [3:0] be, input logic [31:0] wd);
        @(posedge clk);
        n_cs = 0; n_rd = 0; n_wr = 0; n_ale = 0; rd_first = -1; nbeats = 0;
        be_obs = 4'hF; din_rd = '0; err_seen = 0; last_seen = 0;
        cs_bad = 0; dout_bad = 0; ale_rd_bad = 0;
        exp_cs = cs; exp_wd = wd;
        @(negedge clk);
        req_valid = 1; req_cs = 3'(cs); req_we = we; req_burst = burst;
        req_len = 3'(len); req_be = be; req_wdata = wd; req_addr = AW'(cs * 4096 + 17);
        @(negedge clk);
        req_valid = 0;
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk);
            if (last_seen) break;
        end
        if (!last_seen) chk(0, "R10", "response timeout", 0, 1);
    endtask

    // Single-word access with the given timing; checks phase lengths and data.
    task automatic async_read(input string rq, input int cs, input int w, input int s,
                              input int p, input int h, input logic [3:0] be, input bit burst);
        do_req(cs, 0, burst, 0, be, 0);
        chk(n_cs == s + p + h + 3, rq, "cs low clocks", n_cs, s + p + h + 3);
        chk(n_rd == p + 1, rq, "rd low clocks", n_rd, p + 1);
        chk(rd_first == s + 1, rq, "rd start", rd_first, s + 1);
        chk(be_obs == x_be_n(w, be), "R12", "byte enables", be_obs, x_be_n(w, be));
        chk(nbeats == 1 && beat_d[0] == x_mask(w, din_rd), "R6", "read data",
            beat_d[0], x_mask(w, din_rd));
        chk(!cs_bad, "R8", "chip select pattern", cs_bad, 0);
        chk(n_ale == 0, "R11", "no ale on single", n_ale, 0);
    endtask

    task automatic burst_read(input int cs, input int w, input int l, input int len, input int seed);
        int n, k, kl;
        logic [31:0] e;
        wseed = seed;
        do_req(cs, 0, 1, len - 1, 4'h0, 0);
        n = 0; k = l + 2; kl = 0;
        while (n < len && k < 200) begin
            if (((k + seed) % 3) != 0) begin
                e = x_mask(w, {8'hC3, 24'(ale_g + k)});
                chk(beat_d[n] == e, "R10", "burst word", beat_d[n], e);
                chk(beat_l[n] == (n == len - 1), "R10", "last flag", 32'(beat_l[n]), 32'(n == len - 1));
                kl = k;
                n++;
            end
            k++;
        end
        chk(nbeats == len, "R10", "word count", nbeats, len);
        chk(n_ale == 1, "R9", "ale pulses", n_ale, 1);
        chk(!ale_rd_bad, "R9", "rd high during ale", ale_rd_bad, 0);
        chk(n_cs == kl + 1, "R9", "burst cs clocks", n_cs, kl + 1);
        chk(!cs_bad, "R8", "chip select pattern", cs_bad, 0);
        wseed = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "ALL", "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: quiet bus during and after reset.
        repeat (3) @(negedge clk);
        chk(ex_cs_n == 8'hFF && ex_rd_n && ex_wr_n && !ex_ale && !rsp_valid,
            "R1", "bus in reset", {ex_cs_n, ex_rd_n, ex_wr_n, ex_ale, rsp_valid}, {8'hFF, 4'b1100});
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && ex_cs_n == 8'hFF && ex_rd_n && ex_wr_n && !ex_ale && !rsp_valid,
            "R1", "bus after reset", {ex_cs_n, req_ready}, {8'hFF, 1'b1});

        // R2 and R3: boot defaults of chip select 0 for every strap code.
        for (int c = 0; c < 4; c++) begin
            do_reset(c[1], c[0]);
            async_read("R2", 0, c, 15, 15, 15, 4'hF, 0);
        end
        do_reset(1'b0, 1'b1);
        @(negedge clk);
        strap_a7 = 1; strap_a0 = 0;
        async_read("R3", 0, 1, 15, 15, 15, 4'hF, 0);

        // R4: untouched chip selects are disabled.
        for (int c = 1; c < NCS; c++) begin
            do_req(c, 0, 0, 0, 4'hF, 0);
            chk(err_seen && nbeats == 1 && beat_l[0], "R4", "error response", err_seen, 1);
            chk(n_cs == 0 && n_rd == 0 && n_wr == 0 && n_ale == 0, "R4", "bus untouched",
                n_cs + n_rd + n_wr + n_ale, 0);
        end

        // R5 and R6: sweep phase lengths on a 32-bit plain device.
        for (int s = 0; s < 4; s++)
            for (int p = 0; p < 4; p++)
                for (int h = 0; h < 4; h++) begin
                    cfg_write(3, mkcfg(1, 2, 0, s * 2 - s / 3, p + p / 3, h * 2 - h / 3, 0, 0));
                    async_read("R5", 3, 2, s * 2 - s / 3, p + p / 3, h * 2 - h / 3, 4'hF, 0);
                end

        // R7: writes.
        for (int i = 0; i < 4; i++) begin
            cfg_write(3, mkcfg(1, 2, 0, i, 3 - i, i, 0, 0));
            do_req(3, 1, 0, 0, 4'hF, 32'h1234_0000 + 32'(i * 77));
            chk(n_wr == 4 - i && n_rd == 0, "R7", "write strobe", n_wr, 4 - i);
            chk(!dout_bad && !err_seen, "R7", "write data on bus", dout_bad, 0);
            chk(n_cs == i + (3 - i) + i + 3, "R5", "write cs clocks", n_cs, i + 6);
        end

        // R12: byte enables and masking on 16-bit and 8-bit devices.
        cfg_write(4, mkcfg(1, 1, 0, 0, 0, 0, 0, 0));
        cfg_write(5, mkcfg(1, 0, 0, 0, 0, 0, 0, 0));
        for (int b = 0; b < 16; b++) begin
            async_read("R12", 4, 1, 0, 0, 0, 4'(b), 0);
            async_read("R12", 5, 0, 0, 0, 0, 4'(b), 0);
        end

        // R11: single-word forms in sync mode and burst flag in plain mode.
        cfg_write(6, mkcfg(1, 2, 1, 2, 1, 1, 3, 0));
        async_read("R11", 6, 2, 2, 1, 1, 4'hF, 0);
        async_read("R11", 3, 2, 3, 0, 3, 4'hF, 1);

        // R9 and R10: bursts over latency, length and wait patterns.
        for (int l = 0; l < 3; l++)
            for (int n = 0; n < 3; n++)
                for (int sd = 0; sd < 3; sd++) begin
                    cfg_write(6, mkcfg(1, 2, 1, 0, 0, 0, l * 2 + l / 2, 0));
                    burst_read(6, 2, l * 2 + l / 2, (n == 0) ? 1 : (n == 1 ? 4 : 8), sd);
                end
        cfg_write(7, mkcfg(1, 1, 1, 0, 0, 0, 1, 1));
        burst_read(7, 1, 1, 8, 1);

        // R13: sync writes with a mismatched burst code are dropped.
        cfg_write(2, mkcfg(1, 2, 0, 1, 1, 1, 0, 0));
        cfg_write(2, mkcfg(1, 2, 1, 4, 4, 4, 0, 1));
        async_read("R13", 2, 2, 1, 1, 1, 4'hF, 1);
        cfg_write(2, mkcfg(1, 0, 1, 5, 5, 5, 0, 0));
        async_read("R13", 2, 2, 1, 1, 1, 4'hF, 1);
        cfg_write(2, mkcfg(1, 2, 1, 0, 0, 0, 0, 0));
        burst_read(2, 2, 0, 2, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule